// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is the switching core of one node in a two-dimensional mesh network. It has five input and five output channels: one pair toward each neighbouring node (north, east, south, west) and one pair toward the local endpoint. A 5x5 crossbar joins the inputs to the outputs. Packets vary in length and travel as a sequence of fixed-width flits. Every input holds exactly one flit in a register; there is no deeper queue.

A packet's first flit carries signed X and Y hop offsets. The router turns these into one output with dimension-ordered routing, X first. It then claims that output for the packet through a per-output round-robin arbiter. The crossbar connection stays in place until the packet's last flit has left, so a stalled packet keeps holding its path. Claiming an output takes one clock, and each flit move takes one clock. Moves are gated by a valid/ready handshake on every channel. As a routed first flit leaves, its offset in the chosen dimension is moved one step toward zero, so the next node sees the remaining distance.

Top module: `wh_mesh_router`

## Requirements
- R1: While reset is high and in the cycle after it falls, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A flit is `DATA_W+2` bits wide. Bits [DATA_W+1:DATA_W] hold the kind: 0 opens a packet, 1 is a middle flit, 2 closes a packet, 3 is a packet of one flit. In opening and one-flit kinds, data bits [3:0] hold the signed X offset and bits [7:4] hold the signed Y offset.
- R3: Channel indices are 0 north, 1 east, 2 south, 3 west, 4 local. A packet goes east if X>0 and west if X<0. If X is 0 it goes north if Y>0 and south if Y<0. If both offsets are 0 it goes to the local output.
- R4: An opening or one-flit flit leaves with its offset in the chosen dimension moved one step toward zero: X-1 going east, X+1 going west, Y-1 going north, Y+1 going south. A flit going to the local output leaves unchanged. Middle and closing flits always pass unchanged.
- R5: Each input buffers one flit. `in_ready` is high when the buffer is empty or when its flit leaves in that cycle; otherwise it is low and the held flit is kept.
- R6: A one-flit or opening flit accepted at clock edge k, whose output is free and ready, claims the output at edge k+1 and is transferred at edge k+2.
- R7: Once claimed, an output carries only flits from the claiming input until that packet's closing or one-flit flit has transferred. With the output ready, the flits of the packet leave on consecutive edges.
- R8: The transfer of a closing flit frees the output at that edge. A packet waiting for that output is granted at the next edge, so its first flit transfers two edges after the closing flit.
- R9: Each output has a round-robin pointer, reset to 0. Among waiting packets, the grant goes to the first input at or after the pointer in increasing index order, wrapping from 4 to 0. The pointer then moves to one past the granted input.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_flit` stays unchanged on the next cycle.
- R11: Packets bound for different outputs move at the same time. An input is connected to at most one output at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Per input channel: a flit is offered |
| in_ready | output | 5 | Per input channel: the offered flit is taken at this edge |
| in_flit | input | 5 x (DATA_W+2) | Per input channel: offered flit |
| out_valid | output | 5 | Per output channel: a flit is presented |
| out_ready | input | 5 | Per output channel: downstream takes the flit at this edge |
| out_flit | output | 5 x (DATA_W+2) | Per output channel: presented flit |

## Verification
The bench targets the handover of an output between packets. If a design gave priority by input index, the interleaved order of two inputs each sending two packets to the local port would come out grouped, not alternating. If it released the output late or early, the gap after a closing flit would not be exactly two edges. A held downstream stall must keep the flit on the wire and must back-pressure the input through `in_ready`; a design that dropped or overwrote the one-flit buffer would lose or duplicate flits. Five simultaneous one-flit packets bound in five directions check both the route decode and the offset step, including a wrong sign or wrong dimension, and they also check that disjoint paths run in parallel. Long random traffic with random downstream stalls is compared against a behavioural model on every clock.

// File: rtl/wh_pkg.sv
package wh_pkg;

    localparam int NPORT = 5;
    localparam int OFF_W = 4;
    localparam int IDX_W = $clog2(NPORT);

    typedef enum logic [IDX_W-1:0] {
        PORT_N = 3'd0,
        PORT_E = 3'd1,
        PORT_S = 3'd2,
        PORT_W = 3'd3,
        PORT_L = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        FT_HEAD = 2'd0,
        FT_BODY = 2'd1,
        FT_TAIL = 2'd2,
        FT_SOLO = 2'd3
    } ftype_e;

    typedef struct packed {
        logic [OFF_W-1:0] dy;
        logic [OFF_W-1:0] dx;
    } hop_t;

    function automatic logic opens_packet(input logic [1:0] kind);
        return (kind == FT_HEAD) || (kind == FT_SOLO);
    endfunction

    function automatic logic closes_packet(input logic [1:0] kind);
        return (kind == FT_TAIL) || (kind == FT_SOLO);
    endfunction

    function automatic port_e pick_port(input hop_t h);
        if ($signed(h.dx) > 0)       return PORT_E;
        else if ($signed(h.dx) < 0)  return PORT_W;
        else if ($signed(h.dy) > 0)  return PORT_N;
        else if ($signed(h.dy) < 0)  return PORT_S;
        else                         return PORT_L;
    endfunction

    function automatic hop_t step_hop(input hop_t h, input port_e p);
        hop_t r;
        r = h;
        case (p)
            PORT_E:  r.dx = h.dx - 1'b1;
            PORT_W:  r.dx = h.dx + 1'b1;
            PORT_N:  r.dy = h.dy - 1'b1;
            PORT_S:  r.dy = h.dy + 1'b1;
            default: r = h;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wh_in_slot.sv
module wh_in_slot
    import wh_pkg::*;
#(
    parameter int FLIT_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FLIT_W-1:0] in_flit,
    input  logic              pop,
    output logic              in_ready,
    output logic              full,
    output logic              opens,
    output logic              closes,
    output port_e             dest,
    output logic [FLIT_W-1:0] fwd_flit
);

    localparam int HOP_W = 2 * OFF_W;

    logic [FLIT_W-1:0] held;
    logic [1:0]        kind;
    hop_t              hop_now;

    assign kind    = held[FLIT_W-1 -: 2];
    assign hop_now = hop_t'(held[HOP_W-1:0]);

    always_comb begin
        opens    = full && opens_packet(kind);
        closes   = closes_packet(kind);
        dest     = pick_port(hop_now);
        in_ready = !full || pop;
        fwd_flit = held;
        if (opens_packet(kind)) begin
            fwd_flit[HOP_W-1:0] = step_hop(hop_now, dest);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else begin
            if (pop) begin
                full <= 1'b0;
            end
            if (in_valid && in_ready) begin
                full <= 1'b1;
                held <= in_flit;
            end
        end
    end

    // R5: a flit that does not leave stays put and blocks the input
    a_r5_keep_flit: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> (full && $stable(held)));

endmodule

// File: rtl/wh_out_port.sv
module wh_out_port
    import wh_pkg::*;
#(
    parameter int NP = NPORT,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] want,
    input  logic [NP-1:0] src_full,
    input  logic [NP-1:0] src_last,
    input  logic          out_ready,
    output logic          out_valid,
    output logic          xfer,
    output logic          busy,
    output logic [IW-1:0] owner
);

    logic [IW-1:0] ptr;
    logic [IW-1:0] pick;
    logic          hit;

    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int k = 0; k < NP; k++) begin
            if (!hit && want[IW'((int'(ptr) + k) % NP)]) begin
                hit  = 1'b1;
                pick = IW'((int'(ptr) + k) % NP);
            end
        end
    end

    assign out_valid = busy && src_full[owner];
    assign xfer      = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            owner <= '0;
            ptr   <= '0;
        end else if (busy) begin
            if (xfer && src_last[owner]) begin
                busy <= 1'b0;
            end
        end else if (hit) begin
            busy  <= 1'b1;
            owner <= pick;
            ptr   <= (pick == IW'(NP - 1)) ? '0 : pick + 1'b1;
        end
    end

    // R7: connection held until the closing flit moves
    a_r7_hold_owner: assert property (@(posedge clk) disable iff (rst)
        (busy && !(xfer && src_last[owner])) |=> (busy && $stable(owner)));

    // R8: closing flit frees the output at that edge
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (xfer && src_last[owner]) |=> !busy);

    // R10: a stalled flit remains presented
    a_r10_stall_valid: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(owner)));

endmodule

// File: rtl/wh_xbar.sv
module wh_xbar
    import wh_pkg::*;
#(
    parameter int NP     = NPORT,
    parameter int IW     = IDX_W,
    parameter int FLIT_W = 14
) (
    input  logic [NP-1:0][FLIT_W-1:0] src_flit,
    input  logic [NP-1:0][IW-1:0]     owner,
    input  logic [NP-1:0]             busy,
    input  logic [NP-1:0]             xfer,
    output logic [NP-1:0][FLIT_W-1:0] dst_flit,
    output logic [NP-1:0]             pop
);

    for (genvar o = 0; o < NP; o++) begin : g_col
        assign dst_flit[o] = busy[o] ? src_flit[owner[o]] : '0;
    end

    always_comb begin
        pop = '0;
        for (int o = 0; o < NP; o++) begin
            if (xfer[o]) begin
                pop[owner[o]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wh_mesh_router.sv
module wh_mesh_router
    import wh_pkg::*;
#(
    parameter  int DATA_W = 12,
    localparam int FLIT_W = DATA_W + 2,
    localparam int NP     = NPORT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NP-1:0]             in_valid,
    output logic [NP-1:0]             in_ready,
    input  logic [NP-1:0][FLIT_W-1:0] in_flit,
    output logic [NP-1:0]             out_valid,
    input  logic [NP-1:0]             out_ready,
    output logic [NP-1:0][FLIT_W-1:0] out_flit
);

    logic [NP-1:0]             full;
    logic [NP-1:0]             opens;
    logic [NP-1:0]             closes;
    logic [NP-1:0]             pop;
    port_e                     dest [NP];
    logic [NP-1:0][FLIT_W-1:0] fwd_flit;
    logic [NP-1:0][NP-1:0]     want;
    logic [NP-1:0][NP-1:0]     bound;
    logic [NP-1:0]             busy;
    logic [NP-1:0]             xfer;
    logic [NP-1:0][IDX_W-1:0]  owner;

    for (genvar i = 0; i < NP; i++) begin : g_in
        wh_in_slot #(.FLIT_W(FLIT_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid[i]),
            .in_flit  (in_flit[i]),
            .pop      (pop[i]),
            .in_ready (in_ready[i]),
            .full     (full[i]),
            .opens    (opens[i]),
            .closes   (closes[i]),
            .dest     (dest[i]),
            .fwd_flit (fwd_flit[i])
        );
    end

    always_comb begin
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                want[o][i]  = opens[i] && (dest[i] == port_e'(o));
                bound[i][o] = busy[o] && (owner[o] == IDX_W'(i));
            end
        end
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        wh_out_port #(.NP(NP), .IW(IDX_W)) u_port (
            .clk       (clk),
            .rst       (rst),
            .want      (want[o]),
            .src_full  (full),
            .src_last  (closes),
            .out_ready (out_ready[o]),
            .out_valid (out_valid[o]),
            .xfer      (xfer[o]),
            .busy      (busy[o]),
            .owner     (owner[o])
        );

        // R10: stalled flit keeps its value
        a_r10_flit_hold: assert property (@(posedge clk) disable iff (rst)
            (out_valid[o] && !out_ready[o]) |=> $stable(out_flit[o]));
    end

    wh_xbar #(.NP(NP), .IW(IDX_W), .FLIT_W(FLIT_W)) u_xbar (
        .src_flit (fwd_flit),
        .owner    (owner),
        .busy     (busy),
        .xfer     (xfer),
        .dst_flit (out_flit),
        .pop      (pop)
    );

    for (genvar i = 0; i < NP; i++) begin : g_chk
        // R11: an input feeds at most one output
        a_r11_one_path: assert property (@(posedge clk) disable iff (rst)
            $countones(bound[i]) <= 1);
    end

endmodule

// File: tb/test_wh_mesh_router.sv
`timescale 1ns/1ps
module test_wh_mesh_router;

    localparam int FW = 14;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst;
    logic [4:0]          in_valid, in_ready, out_valid, out_ready;
    logic [4:0][FW-1:0]  in_flit, out_flit;

    wh_mesh_router i_wh_mesh_router (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit rand_ready = 0;
    logic [4:0] fixed_ready = 5'h1f;

    logic [FW-1:0] txq  [5][$];
    logic [FW-1:0] got  [5][$];
    int            gotc [5][$];

    bit            m_full [5];
    logic [FW-1:0] m_buf  [5];
    bit            m_busy [5];
    int            m_own  [5];
    int            m_ptr  [5];
    bit            mv [5];
    logic [FW-1:0] mf [5];
    bit            mpop [5];
    bit            mrdy [5];
    bit            acc  [5];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mkflit(input logic [1:0] t, input int id,
                                             input int dx, input int dy);
        return {t, 4'(id), 4'(dy), 4'(dx)};
    endfunction

    function automatic bit f_open(input logic [FW-1:0] f);
        return f[FW-1:FW-2] == 2'd0 || f[FW-1:FW-2] == 2'd3;
    endfunction

    function automatic bit f_close(input logic [FW-1:0] f);
        return f[FW-1:FW-2] == 2'd2 || f[FW-1:FW-2] == 2'd3;
    endfunction

    function automatic int f_dir(input logic [FW-1:0] f);
        int dx, dy;
        dx = $signed(f[3:0]);
        dy = $signed(f[7:4]);
        if (dx > 0) return 1;
        if (dx < 0) return 3;
        if (dy > 0) return 0;
        if (dy < 0) return 2;
        return 4;
    endfunction

    function automatic logic [FW-1:0] f_adj(input logic [FW-1:0] f);
        logic [FW-1:0] r;
        r = f;
        if (f_open(f)) begin
            case (f_dir(f))
                1: r[3:0] = f[3:0] - 4'd1;
                3: r[3:0] = f[3:0] + 4'd1;
                0: r[7:4] = f[7:4] - 4'd1;
                2: r[7:4] = f[7:4] + 4'd1;
                default: r = f;
            endcase
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 5; i++) begin
            m_full[i] = 0; m_buf[i] = '0; m_busy[i] = 0; m_own[i] = 0; m_ptr[i] = 0;
            txq[i].delete(); got[i].delete(); gotc[i].delete();
        end
        cyc = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = '0; in_flit = '0; out_ready = '0;
        model_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: idle outputs, open inputs after reset
        chk(out_valid == 5'h00, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == 5'h1f, "R1", "in_ready after reset", in_ready, 5'h1f);
    endtask

    task automatic cycle();
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            in_valid[i] = txq[i].size() > 0;
            in_flit[i]  = (txq[i].size() > 0) ? txq[i][0] : '0;
        end
        out_ready = rand_ready ? 5'($urandom) : fixed_ready;
        #2;
        for (int o = 0; o < 5; o++) begin
            mv[o] = m_busy[o] && m_full[m_own[o]];
            mf[o] = f_adj(m_buf[m_own[o]]);
        end
        for (int i = 0; i < 5; i++) mpop[i] = 0;
        for (int o = 0; o < 5; o++) if (mv[o] && out_ready[o]) mpop[m_own[o]] = 1;
        for (int i = 0; i < 5; i++) begin
            mrdy[i] = !m_full[i] || mpop[i];
            acc[i]  = in_valid[i] && mrdy[i];
            chk(in_ready[i] === mrdy[i], "R5", $sformatf("in_ready[%0d]", i), in_ready[i], mrdy[i]);
        end
        for (int o = 0; o < 5; o++) begin
            chk(out_valid[o] === mv[o], "R6", $sformatf("out_valid[%0d]", o), out_valid[o], mv[o]);
            if (mv[o]) begin
                chk(out_flit[o] === mf[o], "R4", $sformatf("out_flit[%0d]", o), out_flit[o], mf[o]);
                if (out_ready[o]) begin
                    got[o].push_back(out_flit[o]);
                    gotc[o].push_back(cyc);
                end
            end
        end
        @(posedge clk);
        for (int o = 0; o < 5; o++) begin
            if (m_busy[o]) begin
                if (mv[o] && out_ready[o] && f_close(m_buf[m_own[o]])) m_busy[o] = 0;
            end else begin
                for (int k = 0; k < 5; k++) begin
                    int idx;
                    idx = (m_ptr[o] + k) % 5;
                    if (!m_busy[o] && m_full[idx] && f_open(m_buf[idx]) && f_dir(m_buf[idx]) == o) begin
                        m_busy[o] = 1; m_own[o] = idx; m_ptr[o] = (idx + 1) % 5;
                    end
                end
            end
        end
        for (int i = 0; i < 5; i++) begin
            if (mpop[i]) m_full[i] = 0;
            if (acc[i]) begin
                m_full[i] = 1; m_buf[i] = in_flit[i];
                void'(txq[i].pop_front());
            end
        end
        cyc++;
    endtask

    function automatic bit idle();
        for (int i = 0; i < 5; i++)
            if (txq[i].size() > 0 || m_full[i] || m_busy[i]) return 0;
        return 1;
    endfunction

    task automatic drain(input int maxc);
        int n;
        n = 0;
        while (!idle() && n < maxc) begin
            cycle();
            n++;
        end
        chk(idle(), "R7", "drain within bound", n, maxc);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        int total;
        int seen;
        logic [FW-1:0] hold_a;
        rst = 1'b1; in_valid = '0; in_flit = '0; out_ready = '0;

        // Scenario A: R2 format, R3 east, R4 step, R6 latency, R7 streaming
        do_reset();
        fixed_ready = 5'h1f;
        txq[4].push_back(mkflit(2'd0, 1, 2, 0));
        txq[4].push_back(mkflit(2'd1, 1, 9, 9));
        txq[4].push_back(mkflit(2'd1, 1, 5, 3));
        txq[4].push_back(mkflit(2'd2, 1, 7, 7));
        drain(50);
        chk(got[1].size() == 4, "R3", "east flit count", got[1].size(), 4);
        if (got[1].size() == 4) begin
            chk(got[1][0] == mkflit(2'd0, 1, 1, 0), "R4", "east head offset", got[1][0], mkflit(2'd0, 1, 1, 0));
            chk(got[1][1] == mkflit(2'd1, 1, 9, 9), "R2", "body unchanged", got[1][1], mkflit(2'd1, 1, 9, 9));
            chk(got[1][3] == mkflit(2'd2, 1, 7, 7), "R2", "tail unchanged", got[1][3], mkflit(2'd2, 1, 7, 7));
            chk(gotc[1][0] == 2, "R6", "head transfer edge", gotc[1][0], 2);
            chk(gotc[1][3] - gotc[1][0] == 3, "R7", "consecutive flits", gotc[1][3] - gotc[1][0], 3);
        end

        // Scenario B: R3 every direction, R4 steps, R11 parallel
        do_reset();
        txq[0].push_back(mkflit(2'd3, 2, -1, 0));
        txq[1].push_back(mkflit(2'd3, 3, 0, 3));
        txq[2].push_back(mkflit(2'd3, 4, 0, -2));
        txq[3].push_back(mkflit(2'd3, 5, 0, 0));
        txq[4].push_back(mkflit(2'd3, 6, 1, -3));
        drain(50);
        chk(got[3].size() == 1 && got[3][0] == mkflit(2'd3, 2, 0, 0), "R3", "west route", got[3].size() ? got[3][0] : 0, mkflit(2'd3, 2, 0, 0));
        chk(got[0].size() == 1 && got[0][0] == mkflit(2'd3, 3, 0, 2), "R3", "north route", got[0].size() ? got[0][0] : 0, mkflit(2'd3, 3, 0, 2));
        chk(got[2].size() == 1 && got[2][0] == mkflit(2'd3, 4, 0, -1), "R4", "south step", got[2].size() ? got[2][0] : 0, mkflit(2'd3, 4, 0, -1));
        chk(got[4].size() == 1 && got[4][0] == mkflit(2'd3, 5, 0, 0), "R4", "local unchanged", got[4].size() ? got[4][0] : 0, mkflit(2'd3, 5, 0, 0));
        chk(got[1].size() == 1 && got[1][0] == mkflit(2'd3, 6, 0, -3), "R3", "X before Y", got[1].size() ? got[1][0] : 0, mkflit(2'd3, 6, 0, -3));
        for (int o = 0; o < 5; o++)
            chk(gotc[o].size() == 1 && gotc[o][0] == 2, "R11", $sformatf("parallel edge port %0d", o), gotc[o].size() ? gotc[o][0] : -1, 2);

        // Scenario C: R9 round robin order, R8 handover gap
        do_reset();
        txq[0].push_back(mkflit(2'd0, 1, 0, 0)); txq[0].push_back(mkflit(2'd2, 1, 0, 0));
        txq[0].push_back(mkflit(2'd0, 2, 0, 0)); txq[0].push_back(mkflit(2'd2, 2, 0, 0));
        txq[2].push_back(mkflit(2'd0, 5, 0, 0)); txq[2].push_back(mkflit(2'd2, 5, 0, 0));
        txq[2].push_back(mkflit(2'd0, 6, 0, 0)); txq[2].push_back(mkflit(2'd2, 6, 0, 0));
        drain(80);
        chk(got[4].size() == 8, "R7", "local flit count", got[4].size(), 8);
        if (got[4].size() == 8) begin
            chk(got[4][0][11:8] == 1, "R9", "first packet id", got[4][0][11:8], 1);
            chk(got[4][2][11:8] == 5, "R9", "second packet id", got[4][2][11:8], 5);
            chk(got[4][4][11:8] == 2, "R9", "third packet id", got[4][4][11:8], 2);
            chk(got[4][6][11:8] == 6, "R9", "fourth packet id", got[4][6][11:8], 6);
            chk(gotc[4][2] - gotc[4][1] == 2, "R8", "gap after tail", gotc[4][2] - gotc[4][1], 2);
            chk(got[4][1] == mkflit(2'd2, 1, 0, 0), "R7", "tail follows own head", got[4][1], mkflit(2'd2, 1, 0, 0));
        end

        // Scenario D: R10 stall, R5 back-pressure
        do_reset();
        fixed_ready = 5'h0f;
        txq[3].push_back(mkflit(2'd3, 7, 0, 0));
        txq[3].push_back(mkflit(2'd3, 8, 0, 0));
        repeat (3) cycle();
        @(negedge clk); #1;
        hold_a = out_flit[4];
        chk(out_valid[4] == 1'b1, "R10", "valid during stall", out_valid[4], 1);
        repeat (3) cycle();
        @(negedge clk); #1;
        chk(out_valid[4] == 1'b1, "R10", "valid still held", out_valid[4], 1);
        chk(out_flit[4] == hold_a, "R10", "flit stable", out_flit[4], hold_a);
        chk(in_ready[3] == 1'b0, "R5", "input blocked when full", in_ready[3], 0);
        fixed_ready = 5'h1f;
        drain(50);
        chk(got[4].size() == 2 && got[4][0][11:8] == 7 && got[4][1][11:8] == 8, "R5", "no flit lost", got[4].size(), 2);

        // Scenario E: random traffic and stalls against the model
        do_reset();
        rand_ready = 1;
        total = 0;
        for (int i = 0; i < 5; i++) begin
            for (int p = 0; p < 40; p++) begin
                int len, dx, dy;
                len = 1 + int'($urandom % 4);
                dx = int'($urandom % 5) - 2;
                dy = int'($urandom % 5) - 2;
                if (len == 1) txq[i].push_back(mkflit(2'd3, p % 16, dx, dy));
                else begin
                    txq[i].push_back(mkflit(2'd0, p % 16, dx, dy));
                    for (int b = 0; b < len - 2; b++) txq[i].push_back(mkflit(2'd1, p % 16, b, i));
                    txq[i].push_back(mkflit(2'd2, p % 16, 0, 0));
                end
                total += len;
            end
        end
        drain(20000);
        seen = 0;
        for (int o = 0; o < 5; o++) seen += got[o].size();
        chk(seen == total, "R7", "random flits delivered", seen, total);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule